// File: doc/BRIEF.md
# Serial Command Field Decoder for a Time-Multiplexed Control Link

This block sits behind the frame tracker of a time-multiplexed serial link that carries both audio and control traffic. The link has a 32-bit command field at the start of each frame and may carry extended command fields after it. For each field, the decoder shifts in the bits, MSB first, on the rising bit-clock edge. It then decides whether the field is aimed at this device. A field that addresses the device either writes one register through a register-file write port or reads one register back onto a serial output with an output enable. The output enable controls a tri-state pad outside the block.

The frame tracker marks the first bit of every field with a one-cycle strobe. It also says whether the field is a plain command field or an extended one. The device's acquired chain position is given as a plain ID input. The decoder flags a field that asks for ID assignment and a field that announces extended commands. These flags are for the logic that acquires the ID and for the logic that skips the audio slots. This device is a receive-chain member, so fields for the transmit chain are ignored.

Top module: `tdm_cmd_decoder`

## Requirements
- R1: While reset is asserted and after its release, `wr_en`, `rd_req`, `sdo_oe`, `sdo`, `id_assign` and `emd_seen` are all low.
- R2: A field carries bits 31 to 0, MSB first. Bit 31 is the ID-assign flag, bit 30 the extended flag and bit 29 the chain select. Bits 28:24 are the target ID and bit 23 is the read flag (1 = read). Bits 22:16 are the register address and bits 15:8 the data byte. Bits 7:0 have no effect. A write to an ID equal to `my_id` gives exactly one `wr_en` pulse, with `wr_addr` = bits 22:16 and `wr_data` = bits 15:8. The pulse is visible in the clock cycle after the rising edge that samples bit 8.
- R3: Target ID 5'h1F is a broadcast that is accepted for writes whatever `my_id` is. Target ID 5'h00 selects nothing. Any other ID that differs from `my_id` produces no write and no read.
- R4: A field with chain select (bit 29) = 1 belongs to the transmit chain and produces no write and no read.
- R5: A command field with bit 31 = 1 produces no write and no read. For it, `id_assign` pulses for one cycle, in the cycle after the rising edge that samples bit 31.
- R6: A field started with `fld_ext` = 1 is an extended field. Its bit 31 has no meaning, and it is decoded for writes and reads like a command field with bit 31 = 0. If bit 30 = 1 on an extended field, or on a command field with bit 31 = 0, `emd_seen` pulses for one cycle after the edge that samples bit 30.
- R7: A read to an ID equal to `my_id` pulses `rd_req` with `rd_addr` = bits 22:16 in the cycle after the edge that samples bit 16. `sdo_oe` rises on the falling edge after bit 17 is sampled, one bit period before data. The byte on `rd_data` is then shifted out MSB first on `sdo`, one bit per falling edge, during the bit 15..8 slots.
- R8: `sdo_oe` falls on the falling edge after bit 8 of a read field is sampled. A read field never produces `wr_en`.
- R9: A read aimed at the broadcast ID 5'h1F is ignored: no `rd_req` and no `sdo_oe`.
- R10: A `fld_start` strobe in the middle of a field abandons that field. The abandoned field produces no write, and `sdo_oe` drops no later than the falling edge after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock; input sampled on rising edge, output driven on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fld_start | input | 1 | High during the bit period of a field's first (MSB) bit |
| fld_ext | input | 1 | Qualifies `fld_start`: field is an extended command field |
| sdi | input | 1 | Serial command data in |
| my_id | input | ID_W | Device position acquired on the chain |
| rd_data | input | DAT_W | Register value for `rd_addr`, valid in the `rd_req` cycle |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | REG_W | Register write address |
| wr_data | output | DAT_W | Register write data |
| rd_req | output | 1 | One-cycle register read request |
| rd_addr | output | REG_W | Register read address |
| sdo | output | 1 | Serial read data out |
| sdo_oe | output | 1 | Output enable for the external tri-state driver |
| id_assign | output | 1 | Pulse: field asks for ID assignment |
| emd_seen | output | 1 | Pulse: field announces extended commands |

## Verification
The bench builds the decoder with its default parameters: a 5-bit ID, a 7-bit register address, an 8-bit data byte in a 32-bit field, and the read path enabled. With these values, every field boundary in the requirements falls on the bit index named there. The bench records the cycle in which each write, read request and flag pulse appears. It also records the enable and data bit seen after every falling edge. This makes the one-bit-early enable, the release after the last data bit, and abandoning a read midway all observable at the ports.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

   typedef struct packed {
      logic wr_ok;
      logic rd_ok;
   } tdc_hit_t;

   // Decide whether a header addresses this receive-chain device.
   function automatic tdc_hit_t tdc_decode(
      input logic       assign_flag,
      input logic       chain_sel,
      input logic       is_read,
      input logic       is_ext,
      input logic [7:0] tgt_id,
      input logic [7:0] own_id,
      input int         id_w
   );
      tdc_hit_t   h;
      logic [7:0] all_ones;
      logic       usable;
      all_ones = 8'((9'd1 << id_w) - 9'd1);
      usable   = !(assign_flag && !is_ext) && !chain_sel && (tgt_id != 8'd0);
      h.wr_ok  = usable && !is_read && ((tgt_id == own_id) || (tgt_id == all_ones));
      h.rd_ok  = usable && is_read && (tgt_id == own_id) && (tgt_id != all_ones);
      return h;
   endfunction

endpackage

// File: rtl/tdc_pos_ctr.sv
module tdc_pos_ctr #(
   parameter int FIELD_W = 32,
   localparam int POS_W  = $clog2(FIELD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fld_start,
   output logic [POS_W-1:0] pos
);
   localparam logic [POS_W-1:0] P_LAST = POS_W'(FIELD_W - 1);

   // pos = number of bits of the current field already sampled; 0 = idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (fld_start) begin
         pos <= POS_W'(1);
      end else if (pos == P_LAST) begin
         pos <= '0;
      end else if (pos != '0) begin
         pos <= pos + POS_W'(1);
      end
   end
endmodule

// File: rtl/tdc_hdr_rx.sv
module tdc_hdr_rx
   import tdc_pkg::*;
#(
   parameter int FIELD_W = 32,
   parameter int ID_W    = 5,
   parameter int REG_W   = 7,
   parameter int DAT_W   = 8,
   parameter int READ_EN = 1,
   localparam int POS_W  = $clog2(FIELD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fld_start,
   input  logic             fld_ext,
   input  logic             sdi,
   input  logic [ID_W-1:0]  my_id,
   input  logic [POS_W-1:0] pos,
   output logic             wr_en,
   output logic [REG_W-1:0] wr_addr,
   output logic [DAT_W-1:0] wr_data,
   output logic             rd_req,
   output logic [REG_W-1:0] rd_addr,
   output logic             rd_hit,
   output logic             id_assign,
   output logic             emd_seen
);
   localparam int IDX_RW   = 3 + ID_W;
   localparam int IDX_DAT0 = IDX_RW + 1 + REG_W;
   localparam int IDX_END  = IDX_DAT0 + DAT_W;
   localparam int SR_W     = IDX_END - 1;

   localparam logic [POS_W-1:0] P_EMD  = POS_W'(1);
   localparam logic [POS_W-1:0] P_RW   = POS_W'(IDX_RW);
   localparam logic [POS_W-1:0] P_ADDR = POS_W'(IDX_DAT0 - 1);
   localparam logic [POS_W-1:0] P_WR   = POS_W'(IDX_END - 1);
   localparam logic [POS_W-1:0] P_FEND = POS_W'(FIELD_W - 1);

   logic [SR_W-1:0]    sr;
   logic               ext_q;
   logic               bit_vld;
   logic [IDX_RW:0]    hdr;
   logic [IDX_END-1:0] full;
   tdc_hit_t           hit_hdr;
   tdc_hit_t           hit_full;

   assign bit_vld = fld_start || (pos != '0);
   assign hdr     = {sr[IDX_RW-1:0], sdi};
   assign full    = {sr, sdi};

   always_comb begin
      hit_hdr  = tdc_decode(hdr[IDX_RW], hdr[IDX_RW-2], hdr[0], ext_q,
                            8'(hdr[ID_W:1]), 8'(my_id), ID_W);
      hit_full = tdc_decode(full[IDX_END-1], full[IDX_END-3], full[DAT_W+REG_W], ext_q,
                            8'(full[IDX_END-4 -: ID_W]), 8'(my_id), ID_W);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr        <= '0;
         ext_q     <= 1'b0;
         rd_hit    <= 1'b0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         rd_req    <= 1'b0;
         rd_addr   <= '0;
         id_assign <= 1'b0;
         emd_seen  <= 1'b0;
      end else begin
         wr_en     <= 1'b0;
         rd_req    <= 1'b0;
         id_assign <= 1'b0;
         emd_seen  <= 1'b0;
         if (bit_vld) begin
            sr <= {sr[SR_W-2:0], sdi};
         end
         if (fld_start) begin
            ext_q     <= fld_ext;
            rd_hit    <= 1'b0;
            id_assign <= sdi && !fld_ext;
         end else begin
            if (pos == P_EMD) begin
               emd_seen <= sdi && (ext_q || !sr[0]);
            end
            if (pos == P_RW) begin
               rd_hit <= (READ_EN != 0) && hit_hdr.rd_ok;
            end
            if ((pos == P_ADDR) && rd_hit) begin
               rd_req  <= 1'b1;
               rd_addr <= {sr[REG_W-2:0], sdi};
            end
            if ((pos == P_WR) && hit_full.wr_ok) begin
               wr_en   <= 1'b1;
               wr_addr <= full[DAT_W +: REG_W];
               wr_data <= full[DAT_W-1:0];
            end
            if (pos == P_FEND) begin
               rd_hit <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/tdc_sdo_drv.sv
module tdc_sdo_drv #(
   parameter int FIELD_W = 32,
   parameter int ID_W    = 5,
   parameter int REG_W   = 7,
   parameter int DAT_W   = 8,
   localparam int POS_W  = $clog2(FIELD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [POS_W-1:0] pos,
   input  logic             rd_hit,
   input  logic [DAT_W-1:0] rd_data,
   output logic             sdo,
   output logic             sdo_oe
);
   localparam int IDX_DAT0 = 4 + ID_W + REG_W;
   localparam int IDX_END  = IDX_DAT0 + DAT_W;

   localparam logic [POS_W-1:0] P_PRE  = POS_W'(IDX_DAT0 - 1);
   localparam logic [POS_W-1:0] P_D0   = POS_W'(IDX_DAT0);
   localparam logic [POS_W-1:0] P_DLST = POS_W'(IDX_END - 1);

   logic [DAT_W-1:0] shreg;

   // Falling-edge launch: enable one bit slot ahead of the first data bit.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdo    <= 1'b0;
         sdo_oe <= 1'b0;
         shreg  <= '0;
      end else begin
         sdo_oe <= rd_hit && (pos >= P_PRE) && (pos <= P_DLST);
         if (rd_hit && (pos == P_D0)) begin
            sdo   <= rd_data[DAT_W-1];
            shreg <= rd_data << 1;
         end else if (rd_hit && (pos > P_D0) && (pos <= P_DLST)) begin
            sdo   <= shreg[DAT_W-1];
            shreg <= shreg << 1;
         end else begin
            sdo <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tdm_cmd_decoder.sv
module tdm_cmd_decoder #(
   parameter int FIELD_W = 32,
   parameter int ID_W    = 5,
   parameter int REG_W   = 7,
   parameter int DAT_W   = 8,
   parameter int READ_EN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fld_start,
   input  logic             fld_ext,
   input  logic             sdi,
   input  logic [ID_W-1:0]  my_id,
   input  logic [DAT_W-1:0] rd_data,
   output logic             wr_en,
   output logic [REG_W-1:0] wr_addr,
   output logic [DAT_W-1:0] wr_data,
   output logic             rd_req,
   output logic [REG_W-1:0] rd_addr,
   output logic             sdo,
   output logic             sdo_oe,
   output logic             id_assign,
   output logic             emd_seen
);
   localparam int POS_W   = $clog2(FIELD_W);
   localparam int HDR_END = 4 + ID_W + REG_W + DAT_W;

   if (FIELD_W < HDR_END) begin : g_bad_field
      $error("FIELD_W too small for header layout");
   end
   if (ID_W < 2 || ID_W > 8) begin : g_bad_id
      $error("ID_W must be 2..8");
   end
   if (REG_W < 2 || DAT_W < 2) begin : g_bad_fields
      $error("REG_W and DAT_W must be at least 2");
   end

   logic [POS_W-1:0] pos;
   logic             rd_hit;

   tdc_pos_ctr #(.FIELD_W(FIELD_W)) u_pos (
      .clk       (clk),
      .rst_n     (rst_n),
      .fld_start (fld_start),
      .pos       (pos)
   );

   tdc_hdr_rx #(
      .FIELD_W(FIELD_W), .ID_W(ID_W), .REG_W(REG_W), .DAT_W(DAT_W), .READ_EN(READ_EN)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .fld_start (fld_start),
      .fld_ext   (fld_ext),
      .sdi       (sdi),
      .my_id     (my_id),
      .pos       (pos),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .rd_hit    (rd_hit),
      .id_assign (id_assign),
      .emd_seen  (emd_seen)
   );

   if (READ_EN != 0) begin : g_tx
      tdc_sdo_drv #(
         .FIELD_W(FIELD_W), .ID_W(ID_W), .REG_W(REG_W), .DAT_W(DAT_W)
      ) u_tx (
         .clk     (clk),
         .rst_n   (rst_n),
         .pos     (pos),
         .rd_hit  (rd_hit),
         .rd_data (rd_data),
         .sdo     (sdo),
         .sdo_oe  (sdo_oe)
      );
   end else begin : g_no_tx
      assign sdo    = 1'b0;
      assign sdo_oe = 1'b0;
   end
endmodule

// File: rtl/tdm_cmd_decoder_chk.sv
module tdm_cmd_decoder_chk (
   input logic clk,
   input logic rst_n,
   input logic fld_start,
   input logic wr_en,
   input logic rd_req,
   input logic sdo_oe,
   input logic id_assign
);
   p_wr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   p_rd_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   p_oe_before_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sdo_oe) && !fld_start) |=> rd_req);

   p_no_write_while_driving_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> !wr_en);

   p_assign_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      id_assign |-> $past(fld_start));
endmodule

bind tdm_cmd_decoder tdm_cmd_decoder_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fld_start (fld_start),
   .wr_en     (wr_en),
   .rd_req    (rd_req),
   .sdo_oe    (sdo_oe),
   .id_assign (id_assign)
);

// File: tb/tb_tdm_cmd_decoder.sv
module tb_tdm_cmd_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fld_start = 1'b0;
   logic       fld_ext = 1'b0;
   logic       sdi = 1'b0;
   logic [4:0] my_id = 5'd5;
   logic [7:0] rd_data;
   logic       wr_en, rd_req, sdo, sdo_oe, id_assign, emd_seen;
   logic [6:0] wr_addr, rd_addr;
   logic [7:0] wr_data;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   // register-file model: value derived from address
   function automatic logic [7:0] reg_model(input logic [6:0] a);
      return {a, 1'b1} ^ 8'h3C;
   endfunction
   assign rd_data = reg_model(rd_addr);

   tdm_cmd_decoder dut (
      .clk(clk), .rst_n(rst_n), .fld_start(fld_start), .fld_ext(fld_ext), .sdi(sdi),
      .my_id(my_id), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_req(rd_req), .rd_addr(rd_addr), .sdo(sdo), .sdo_oe(sdo_oe),
      .id_assign(id_assign), .emd_seen(emd_seen)
   );

   // {ext, field, exp_wr, exp_rd, exp_ida, exp_emd}
   localparam logic [36:0] VEC [12] = '{
      {1'b0, 32'h05123CFF, 4'b1000},
      {1'b0, 32'h06123C00, 4'b0000},
      {1'b0, 32'h1F7F8100, 4'b1000},
      {1'b0, 32'h00123C00, 4'b0000},
      {1'b0, 32'h25123C00, 4'b0000},
      {1'b0, 32'h85123C00, 4'b0010},
      {1'b0, 32'h05A20000, 4'b0100},
      {1'b0, 32'h06A20000, 4'b0000},
      {1'b0, 32'h1FA20000, 4'b0000},
      {1'b1, 32'h85345600, 4'b1000},
      {1'b0, 32'h45011100, 4'b1001},
      {1'b0, 32'h25A20000, 4'b0000}
   };

   function automatic string vec_tag(input int i);
      case (i)
         0: return "R2";
         1, 2, 3: return "R3";
         4, 11: return "R4";
         5: return "R5";
         6, 7: return "R7";
         8: return "R9";
         default: return "R6";
      endcase
   endfunction

   logic       oe_log [34];
   logic       sdo_log [34];
   int         wr_n, rd_n, ida_n, emd_n, wr_it, rd_it, ida_it, emd_it;
   logic [6:0] cap_wa, cap_ra;
   logic [7:0] cap_wd;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_field(input logic [31:0] f, input logic ext, input int nbits, input int tail);
      wr_n = 0; rd_n = 0; ida_n = 0; emd_n = 0;
      wr_it = -1; rd_it = -1; ida_it = -1; emd_it = -1;
      for (int k = 0; k < nbits + tail; k++) begin
         @(negedge clk);
         #1;
         oe_log[k]  = sdo_oe;
         sdo_log[k] = sdo;
         if (wr_en) begin wr_n++; wr_it = k; cap_wa = wr_addr; cap_wd = wr_data; end
         if (rd_req) begin rd_n++; rd_it = k; cap_ra = rd_addr; end
         if (id_assign) begin ida_n++; ida_it = k; end
         if (emd_seen) begin emd_n++; emd_it = k; end
         if (k < nbits) begin
            sdi = f[31-k]; fld_start = (k == 0); fld_ext = ext;
         end else begin
            sdi = 1'b0; fld_start = 1'b0; fld_ext = 1'b0;
         end
      end
   endtask

   task automatic check_field(input logic [31:0] f, input bit ew, input bit er,
                              input bit ei, input bit ee, input string tag);
      int oe_bad;
      logic [7:0] got;
      chk(wr_n == (ew ? 1 : 0) && (!ew || wr_it == 24), tag, "write pulse count/cycle", wr_n, ew);
      if (ew) chk({cap_wa, cap_wd} == {f[22:16], f[15:8]}, "R2", "write addr/data",
                  {cap_wa, cap_wd}, {f[22:16], f[15:8]});
      chk(rd_n == (er ? 1 : 0) && (!er || (rd_it == 16 && cap_ra == f[22:16])), tag,
          "read request count/addr", rd_n, er);
      oe_bad = 0;
      for (int k = 1; k < 34; k++)
         if (oe_log[k] != (er && k >= 15 && k <= 23)) oe_bad++;
      chk(oe_bad == 0, er ? "R8" : tag, "output enable window mismatches", oe_bad, 0);
      if (er) begin
         got = '0;
         for (int k = 16; k < 24; k++) got[23-k] = sdo_log[k];
         chk(got == reg_model(f[22:16]), "R7", "serial read byte", got, reg_model(f[22:16]));
      end
      chk(ida_n == (ei ? 1 : 0) && (!ei || ida_it == 1), ei ? "R5" : tag, "id assign pulse", ida_n, ei);
      chk(emd_n == (ee ? 1 : 0) && (!ee || emd_it == 2), ee ? "R6" : tag, "extended flag pulse", emd_n, ee);
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            failures++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk({wr_en, rd_req, sdo_oe, sdo, id_assign, emd_seen} == 6'b0, "R1", "outputs in reset",
          {wr_en, rd_req, sdo_oe, sdo, id_assign, emd_seen}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk({wr_en, rd_req, sdo_oe, sdo, id_assign, emd_seen} == 6'b0, "R1", "outputs after reset",
          {wr_en, rd_req, sdo_oe, sdo, id_assign, emd_seen}, 0);

      // table walk
      for (int i = 0; i < 12; i++) begin
         run_field(VEC[i][35:4], VEC[i][36], 32, 2);
         check_field(VEC[i][35:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], vec_tag(i));
      end

      // R3: other own ID -> direct write ignored, broadcast still accepted
      my_id = 5'd9;
      run_field(32'h05123C00, 1'b0, 32, 2);
      check_field(32'h05123C00, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
      run_field(32'h1F2B9900, 1'b0, 32, 2);
      check_field(32'h1F2B9900, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
      my_id = 5'd5;

      // R10: write abandoned after 12 bits, restarted with non-matching field
      run_field(32'h05123C00, 1'b0, 12, 0);
      run_field(32'h06123C00, 1'b0, 32, 2);
      check_field(32'h06123C00, 1'b0, 1'b0, 1'b0, 1'b0, "R10");

      // R10: read abandoned mid data phase; enable must drop
      run_field(32'h05A20000, 1'b0, 19, 0);
      chk(oe_log[18] == 1'b1, "R10", "enable active before abort", oe_log[18], 1);
      run_field(32'h06123C00, 1'b0, 32, 2);
      check_field(32'h06123C00, 1'b0, 1'b0, 1'b0, 1'b0, "R10");

      // back-to-back read then write to own ID
      run_field(32'h05DD0000, 1'b0, 32, 0);
      check_field(32'h05DD0000, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
      run_field(32'h0577AA00, 1'b0, 32, 2);
      check_field(32'h0577AA00, 1'b1, 1'b0, 1'b0, 1'b0, "R2");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule